// File: doc/BRIEF.md
# OLED Controller Power-Up Sequencer

This block brings a 128x32 monochrome OLED display controller out of reset and configures it over a write-only serial link. On a start request it drives the panel reset line low for a timed interval. It then asserts chip select and feeds a fixed list of 26 configuration bytes to an external SPI shifter, one byte per valid/ready handshake. It releases chip select only after the shifter has finished the last byte. When the list is done it raises a done flag. The data/command select line stays in command mode throughout, because pixel transfer is outside this block.

Two short operations share the same datapath. Sleep-enter sends the display-off command inside its own chip-select frame. Sleep-exit sends the display-on command, then keeps chip select asserted for a timed settling interval before releasing it. All delays are counted in clock cycles from a cycles-per-millisecond parameter.

The controller is one state machine with six states. Idle (`ST_IDLE`) waits for a request. Reset-low (`ST_RST_LOW`) holds the panel in reset. Select (`ST_CS_ON`) asserts chip select one cycle ahead of the first byte. Send (`ST_SEND`) offers the bytes. Drain (`ST_DRAIN`) waits for the shifter to finish. Wake-hold (`ST_WAKE_HOLD`) counts out the settling time after sleep-exit. The transitions are:
- Idle to reset-low on start.
- Idle to select on a sleep request.
- Reset-low to select when the reset timer expires.
- Select to send unconditionally.
- Send to itself while bytes remain.
- Send to drain once the last byte is accepted.
- Drain to idle, or drain to wake-hold for sleep-exit, once the shifter is ready again.
- Wake-hold to idle when its timer expires.

Top module: `oled_pwrup_seq`

## Requirements
- R1: After reset the outputs are in this state: cs_n=1, dc=0, oled_rst_n=1, tx_valid=0, busy=0, done=0.
- R2: A start pulse in idle drives oled_rst_n low for exactly RST_LOW_MS*CYC_PER_MS cycles, and cs_n stays 1 throughout. Then cs_n goes to 0 for one cycle before the first byte is offered.
- R3: The start sequence sends exactly these 26 bytes, in this order: AE, D5, 80, A8, 1F, D3, 00, 40, 8D, 14, 20, 02, A1, C8, DA, 02, 81, CF, D9, F1, DB, 40, 2E, A4, A6, AF. The byte after 8D is 14 when PUMP_ON=1 and 10 otherwise.
- R4: A byte is transferred on a clock edge where tx_valid=1 and tx_ready=1. While tx_valid=1 and tx_ready=0, tx_valid and tx_byte hold steady. The shifter lowers tx_ready in the cycle after it accepts a byte and raises it again when shifting is done.
- R5: dc is always 0 (command mode). Every transferred byte is sent with cs_n=0 and oled_rst_n=1.
- R6: After the last byte of a frame, cs_n stays 0 until tx_ready has returned to 1. It rises one cycle after the state machine sees that ready, so chip select never drops while the shifter is busy.
- R7: done rises in the same cycle that busy falls at the end of a start sequence. It clears once a start is accepted. Sleep operations leave it unchanged.
- R8: A sleep_on pulse in idle asserts cs_n, sends the single byte AE, releases cs_n, and does not pulse oled_rst_n.
- R9: A sleep_off pulse in idle sends the single byte AF. After the shifter finishes it, cs_n is held at 0 for WAKE_MS*CYC_PER_MS further cycles before it is released.
- R10: start, sleep_on and sleep_off are ignored while busy=1. They cause no extra bytes and no extra reset pulse, and nothing is queued.
- R11: When more than one request is present in idle in the same cycle, the priority order is start first, then sleep_on, then sleep_off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block |
| start | input | 1 | Request for the full power-up sequence |
| sleep_on | input | 1 | Request to enter sleep (display off) |
| sleep_off | input | 1 | Request to leave sleep (display on plus settling) |
| tx_ready | input | 1 | Shifter can accept a byte |
| tx_byte | output | 8 | Byte offered to the shifter |
| tx_valid | output | 1 | tx_byte is valid |
| dc | output | 1 | Data/command select, 0 = command |
| cs_n | output | 1 | Active-low chip select to the panel |
| oled_rst_n | output | 1 | Active-low reset to the panel |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | Power-up sequence completed |

## Verification
The bench builds the block with CYC_PER_MS=4, so the reset pulse is 72 cycles and the wake settling is 200 cycles. Both intervals can then be counted exactly, cycle by cycle, in a short run. The other parameters keep their defaults, so the byte list includes the pump-enable value. The shifter model has a bench-controlled shift length of 1 or 3 cycles. This exercises both back-to-back byte handoff and longer back-pressure on the handshake and on chip-select release.

// File: rtl/oled_seq_pkg.sv
package oled_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_LOW,
        ST_CS_ON,
        ST_SEND,
        ST_DRAIN,
        ST_WAKE_HOLD
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_INIT,
        OP_SLEEP,
        OP_WAKE
    } seq_op_t;

    localparam int INIT_LEN = 26;
    localparam logic [7:0] CMD_DISP_OFF = 8'hAE;
    localparam logic [7:0] CMD_DISP_ON  = 8'hAF;

    // Configuration list; pump_arg is the byte following the pump command
    function automatic logic [7:0] init_byte(input logic [4:0] idx, input logic [7:0] pump_arg);
        logic [7:0] b;
        unique case (idx)
            5'd0:  b = CMD_DISP_OFF;
            5'd1:  b = 8'hD5;
            5'd2:  b = 8'h80;
            5'd3:  b = 8'hA8;
            5'd4:  b = 8'h1F;
            5'd5:  b = 8'hD3;
            5'd6:  b = 8'h00;
            5'd7:  b = 8'h40;
            5'd8:  b = 8'h8D;
            5'd9:  b = pump_arg;
            5'd10: b = 8'h20;
            5'd11: b = 8'h02;
            5'd12: b = 8'hA1;
            5'd13: b = 8'hC8;
            5'd14: b = 8'hDA;
            5'd15: b = 8'h02;
            5'd16: b = 8'h81;
            5'd17: b = 8'hCF;
            5'd18: b = 8'hD9;
            5'd19: b = 8'hF1;
            5'd20: b = 8'hDB;
            5'd21: b = 8'h40;
            5'd22: b = 8'h2E;
            5'd23: b = 8'hA4;
            5'd24: b = 8'hA6;
            5'd25: b = CMD_DISP_ON;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/oled_delay_timer.sv
module oled_delay_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_ni,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/oled_cmd_rom.sv
module oled_cmd_rom
    import oled_seq_pkg::*;
#(
    parameter bit PUMP_ON = 1'b1,
    parameter int IDX_W   = 5
) (
    input  seq_op_t          op,
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       cmd,
    output logic             last
);
    localparam logic [7:0] PUMP_ARG = PUMP_ON ? 8'h14 : 8'h10;

    logic [4:0] idx5;
    assign idx5 = 5'(idx);

    always_comb begin
        unique case (op)
            OP_SLEEP: begin
                cmd  = CMD_DISP_OFF;
                last = 1'b1;
            end
            OP_WAKE: begin
                cmd  = CMD_DISP_ON;
                last = 1'b1;
            end
            default: begin
                cmd  = init_byte(idx5, PUMP_ARG);
                last = (idx5 == 5'(INIT_LEN - 1));
            end
        endcase
    end
endmodule

// File: rtl/oled_pwrup_seq.sv
module oled_pwrup_seq
    import oled_seq_pkg::*;
#(
    parameter int CYC_PER_MS = 50000,
    parameter int RST_LOW_MS = 18,
    parameter int WAKE_MS    = 50,
    parameter bit PUMP_ON    = 1'b1
) (
    input  logic       clk,
    input  logic       rst_ni,
    input  logic       start,
    input  logic       sleep_on,
    input  logic       sleep_off,
    input  logic       tx_ready,
    output logic [7:0] tx_byte,
    output logic       tx_valid,
    output logic       dc,
    output logic       cs_n,
    output logic       oled_rst_n,
    output logic       busy,
    output logic       done
);
    localparam int RST_CYC  = RST_LOW_MS * CYC_PER_MS;
    localparam int WAKE_CYC = WAKE_MS * CYC_PER_MS;
    localparam int MAX_CYC  = (RST_CYC > WAKE_CYC) ? RST_CYC : WAKE_CYC;
    localparam int TMR_W    = $clog2(MAX_CYC + 1);
    localparam int IDX_W    = $clog2(INIT_LEN);

    seq_state_t       state_q, state_d;
    seq_op_t          op_q, op_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             done_q, done_d;
    logic             tmr_load, tmr_zero;
    logic [TMR_W-1:0] tmr_val;
    logic [7:0]       rom_cmd;
    logic             rom_last;

    oled_delay_timer #(.W(TMR_W)) i_timer (
        .clk      (clk),
        .rst_ni   (rst_ni),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    oled_cmd_rom #(.PUMP_ON(PUMP_ON), .IDX_W(IDX_W)) i_rom (
        .op   (op_q),
        .idx  (idx_q),
        .cmd  (rom_cmd),
        .last (rom_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            op_q    <= OP_INIT;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            op_q    <= op_d;
            idx_q   <= idx_d;
            done_q  <= done_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        op_d     = op_q;
        idx_d    = idx_q;
        done_d   = done_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    op_d     = OP_INIT;
                    idx_d    = '0;
                    done_d   = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(RST_CYC - 1);
                    state_d  = ST_RST_LOW;
                end else if (sleep_on) begin
                    op_d    = OP_SLEEP;
                    idx_d   = '0;
                    state_d = ST_CS_ON;
                end else if (sleep_off) begin
                    op_d    = OP_WAKE;
                    idx_d   = '0;
                    state_d = ST_CS_ON;
                end
            end
            ST_RST_LOW: begin
                if (tmr_zero) state_d = ST_CS_ON;
            end
            ST_CS_ON: begin
                state_d = ST_SEND;
            end
            ST_SEND: begin
                if (tx_ready) begin
                    if (rom_last) state_d = ST_DRAIN;
                    else          idx_d   = idx_q + 1'b1;
                end
            end
            ST_DRAIN: begin
                if (tx_ready) begin
                    if (op_q == OP_WAKE) begin
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(WAKE_CYC - 1);
                        state_d  = ST_WAKE_HOLD;
                    end else begin
                        if (op_q == OP_INIT) done_d = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_WAKE_HOLD: begin
                if (tmr_zero) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        tx_byte    = rom_cmd;
        tx_valid   = 1'b0;
        dc         = 1'b0;
        cs_n       = 1'b1;
        oled_rst_n = 1'b1;
        busy       = 1'b1;
        done       = done_q;
        unique case (state_q)
            ST_IDLE:      busy = 1'b0;
            ST_RST_LOW:   oled_rst_n = 1'b0;
            ST_CS_ON:     cs_n = 1'b0;
            ST_SEND: begin
                cs_n     = 1'b0;
                tx_valid = 1'b1;
            end
            ST_DRAIN:     cs_n = 1'b0;
            ST_WAKE_HOLD: cs_n = 1'b0;
            default:      busy = 1'b1;
        endcase
    end
endmodule

// File: rtl/oled_seq_chk.sv
module oled_seq_chk (
    input logic       clk,
    input logic       rst_ni,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_byte,
    input logic       cs_n,
    input logic       oled_rst_n,
    input logic       busy,
    input logic       done
);
    // R2: panel reset never overlaps chip select
    a_r2_cs_off_in_reset: assert property (@(posedge clk) disable iff (!rst_ni)
        !oled_rst_n |-> cs_n);

    // R10: reset pulse only as part of a running sequence
    a_r10_rst_only_busy: assert property (@(posedge clk) disable iff (!rst_ni)
        !oled_rst_n |-> busy);

    // R4: offered byte held while shifter not ready
    a_r4_valid_hold: assert property (@(posedge clk) disable iff (!rst_ni)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

    // R5: bytes only offered inside a frame, out of reset
    a_r5_valid_in_frame: assert property (@(posedge clk) disable iff (!rst_ni)
        tx_valid |-> (!cs_n && oled_rst_n));

    // R7: done rises together with the end of busy
    a_r7_done_at_end: assert property (@(posedge clk) disable iff (!rst_ni)
        $rose(done) |-> (!busy && $past(busy)));
endmodule

bind oled_pwrup_seq oled_seq_chk i_chk (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_byte    (tx_byte),
    .cs_n       (cs_n),
    .oled_rst_n (oled_rst_n),
    .busy       (busy),
    .done       (done)
);

// File: tb/test_oled_pwrup_seq.sv
`timescale 1ns/1ps
module test_oled_pwrup_seq;
    localparam int CPM      = 4;
    localparam int RST_CYC  = 18 * CPM;
    localparam int WAKE_CYC = 50 * CPM;

    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic       start = 1'b0, sleep_on = 1'b0, sleep_off = 1'b0;
    logic       tx_ready = 1'b1;
    logic [7:0] tx_byte;
    logic       tx_valid, dc, cs_n, oled_rst_n, busy, done;

    always #10 clk = ~clk;

    oled_pwrup_seq #(.CYC_PER_MS(CPM)) i_oled_pwrup_seq (
        .clk(clk), .rst_ni(rst_ni), .start(start), .sleep_on(sleep_on),
        .sleep_off(sleep_off), .tx_ready(tx_ready), .tx_byte(tx_byte),
        .tx_valid(tx_valid), .dc(dc), .cs_n(cs_n), .oled_rst_n(oled_rst_n),
        .busy(busy), .done(done)
    );

    int n_chk = 0, n_bad = 0;
    int shift_len = 1;
    int sh_cnt = 0;
    logic [7:0] log_b [0:63];
    int n_log = 0, bad_frame = 0;
    int rst_low_cnt = 0, rst_cs_bad = 0, rst_pulses = 0, tail = 0, cs_early = 0, hold_bad = 0;
    logic prev_rst = 1'b1, prev_cs = 1'b1, prev_v = 1'b0, prev_r = 1'b1;
    logic [7:0] prev_b = '0;
    logic [7:0] exp_init [0:25];
    int cyc = 0;

    initial begin
        exp_init = '{8'hAE, 8'hD5, 8'h80, 8'hA8, 8'h1F, 8'hD3, 8'h00, 8'h40, 8'h8D, 8'h14,
                     8'h20, 8'h02, 8'hA1, 8'hC8, 8'hDA, 8'h02, 8'h81, 8'hCF, 8'hD9, 8'hF1,
                     8'hDB, 8'h40, 8'h2E, 8'hA4, 8'hA6, 8'hAF};
    end

    // Shifter model (R4): drops ready after accept, raises it after shift_len cycles
    always @(posedge clk) begin
        if (!rst_ni) begin
            tx_ready <= 1'b1;
            sh_cnt   <= 0;
        end else if (tx_ready) begin
            if (tx_valid) begin
                if (n_log < 64) log_b[n_log] = tx_byte;
                n_log = n_log + 1;
                if (cs_n || dc || !oled_rst_n) bad_frame = bad_frame + 1;
                tx_ready <= 1'b0;
                sh_cnt   <= shift_len;
            end
        end else begin
            if (sh_cnt <= 1) tx_ready <= 1'b1;
            sh_cnt <= sh_cnt - 1;
        end
    end

    // Monitor away from the active edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_ni) begin
            if (!oled_rst_n) rst_low_cnt = rst_low_cnt + 1;
            if (!oled_rst_n && !cs_n) rst_cs_bad = rst_cs_bad + 1;
            if (prev_rst && !oled_rst_n) rst_pulses = rst_pulses + 1;
            if (!cs_n && tx_ready && !tx_valid) tail = tail + 1;
            if (!prev_cs && cs_n && !tx_ready) cs_early = cs_early + 1;
            if (prev_v && !prev_r && (!tx_valid || tx_byte != prev_b)) hold_bad = hold_bad + 1;
        end
        prev_rst = oled_rst_n; prev_cs = cs_n; prev_v = tx_valid;
        prev_r = tx_ready; prev_b = tx_byte;
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog
    always @(negedge clk) begin
        if (cyc > 150000) begin
            n_chk = n_chk + 1; n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cyc);
            summary();
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        n_log = 0; bad_frame = 0; rst_low_cnt = 0; rst_cs_bad = 0;
        rst_pulses = 0; tail = 0; cs_early = 0; hold_bad = 0;
    endtask

    task automatic req(input logic s, input logic on, input logic off);
        @(negedge clk);
        start = s; sleep_on = on; sleep_off = off;
        @(negedge clk);
        start = 1'b0; sleep_on = 1'b0; sleep_off = 1'b0;
    endtask

    task automatic wait_idle();
        int k = 0;
        while (busy && k < 5000) begin
            @(negedge clk);
            k++;
        end
        check("R10 sequence finishes", int'(busy), 0);
    endtask

    task automatic t_reset();
        check("R1 cs_n", int'(cs_n), 1);
        check("R1 dc", int'(dc), 0);
        check("R1 oled_rst_n", int'(oled_rst_n), 1);
        check("R1 tx_valid", int'(tx_valid), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
    endtask

    task automatic t_init(input int sl);
        shift_len = sl;
        clear_mon();
        req(1'b1, 1'b0, 1'b0);
        check("R7 done cleared on start", int'(done), 0);
        check("R2 busy after start", int'(busy), 1);
        wait_idle();
        check("R2 reset low cycles", rst_low_cnt, RST_CYC);
        check("R2 cs_n high during reset", rst_cs_bad, 0);
        check("R2 one reset pulse", rst_pulses, 1);
        check("R3 byte count", n_log, 26);
        for (int i = 0; i < 26; i++) check("R3 byte order", int'(log_b[i]), int'(exp_init[i]));
        check("R5 framed command bytes", bad_frame, 0);
        check("R5 dc command", int'(dc), 0);
        check("R4 valid held under backpressure", hold_bad, 0);
        check("R6 cs idle-ready cycles", tail, 2);
        check("R6 cs not released while shifting", cs_early, 0);
        check("R7 done after init", int'(done), 1);
    endtask

    task automatic t_sleep_on();
        shift_len = 3;
        clear_mon();
        req(1'b0, 1'b1, 1'b0);
        wait_idle();
        check("R8 one byte", n_log, 1);
        check("R8 display off byte", int'(log_b[0]), 8'hAE);
        check("R8 no reset pulse", rst_pulses, 0);
        check("R8 framed", bad_frame, 0);
        check("R6 cs release after shift", cs_early, 0);
        check("R6 sleep frame tail", tail, 2);
        check("R7 done kept by sleep", int'(done), 1);
    endtask

    task automatic t_sleep_off();
        shift_len = 3;
        clear_mon();
        req(1'b0, 1'b0, 1'b1);
        wait_idle();
        check("R9 one byte", n_log, 1);
        check("R9 display on byte", int'(log_b[0]), 8'hAF);
        check("R9 cs held for wake time", tail, 2 + WAKE_CYC);
        check("R9 no reset pulse", rst_pulses, 0);
        check("R7 done kept by wake", int'(done), 1);
    endtask

    task automatic t_busy_ignore();
        shift_len = 1;
        clear_mon();
        req(1'b1, 1'b0, 1'b0);
        repeat (10) @(negedge clk);
        req(1'b1, 1'b0, 1'b0);
        req(1'b0, 1'b1, 1'b0);
        repeat (RST_CYC) @(negedge clk);
        req(1'b0, 1'b0, 1'b1);
        req(1'b1, 1'b1, 1'b1);
        wait_idle();
        repeat (4) @(negedge clk);
        check("R10 no restart reset pulse", rst_pulses, 1);
        check("R10 no extra bytes", n_log, 26);
        check("R10 nothing queued", int'(busy), 0);
    endtask

    task automatic t_priority();
        shift_len = 1;
        clear_mon();
        req(1'b1, 1'b1, 1'b1);
        wait_idle();
        check("R11 start wins: reset pulse", rst_pulses, 1);
        check("R11 start wins: bytes", n_log, 26);
        clear_mon();
        req(1'b0, 1'b1, 1'b1);
        wait_idle();
        check("R11 sleep_on wins: bytes", n_log, 1);
        check("R11 sleep_on wins: byte", int'(log_b[0]), 8'hAE);
        check("R11 sleep_on wins: tail", tail, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
        t_reset();
        t_init(1);
        t_sleep_on();
        t_sleep_off();
        t_init(3);
        t_busy_ignore();
        t_priority();
        summary();
    end
endmodule